// File: doc/BRIEF.md
# Framebuffer Control Register File with Vertical-Sync Interrupt

This block is the control and status register file of a simple framebuffer controller. It decodes a 32-byte, byte-addressed register window. A host writes a control byte whose top bit arms a vertical-sync interrupt. The display pipeline pulses an end-of-frame strobe once per frame. When the interrupt is armed, that strobe latches a pending flag, and the flag drives a level interrupt line.

The host reads the status register to see the pending flag. That read also returns fixed identification bits for the board type and the monitor sense code. The host acknowledges the interrupt by writing anything to the status register; the written data is discarded. Fourteen more byte registers in the upper half of the window act as plain scratch storage. The lower half of the window reads as zero and ignores writes. Writes take effect at the clock edge on a single-cycle strobe, and read data is combinational from the address.

Top module: `fbc_regfile`

## Requirements
- R1: After reset the interrupt output is low, and the control byte, the pending flag and all fourteen storage bytes read as zero.
- R2: Offset 0x10 is the control byte. A write stores the low byte of the write data, and a read returns it. Bit 7 of this byte arms the interrupt.
- R3: A read of offset 0x11 returns the pending flag in bit 7, ORed with the constant 0x61 (bits 6:5 are the monitor code 3, and bit 0 marks a colour board).
- R4: An end-of-frame strobe while control bit 7 is 1 sets the pending flag and raises the interrupt one clock later. A strobe while control bit 7 is 0 changes nothing.
- R5: Any write to offset 0x11 clears the pending flag and lowers the interrupt one clock later, whatever the data. No written value is stored, so a later status read still shows only 0x61.
- R6: Offsets 0x12 to 0x1F are independent byte registers. Each one reads back the low byte last written to it.
- R7: Offsets 0x00 to 0x0F always read zero. Writes to them change neither those reads nor any other register.
- R8: When an armed end-of-frame strobe and a status write fall in the same cycle, the set wins and the interrupt stays high.
- R9: Read data bits above bit 7 are always zero.
- R10: The interrupt is a level. It stays high across later cycles until a status write clears it, and it always equals bit 7 of the status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte offset within the register window |
| bus_wen | input | 1 | Single-cycle write strobe |
| bus_wdata | input | DATA_W | Write data; only bits 7:0 are used |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| frame_end | input | 1 | One-cycle end-of-frame pulse |
| irq | output | 1 | Level vertical-sync interrupt |

## Verification
Read data is combinational. The bench therefore samples it a short settle time after it changes the address, in the same cycle and with no clock edge in between. A write or an end-of-frame strobe is driven on a falling edge and acts on the next rising edge. The bench checks the resulting register value or interrupt level on the falling edge that follows, so exactly one register stage lies between stimulus and check. The no-effect cases are read back through the bus after the stimulus and before any other write.

// File: rtl/fbc_regfile.sv
module fbc_regfile #(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 32,
  parameter int CTRL_OFS   = 16,
  parameter int STAT_OFS   = 17,
  parameter int STORE_BASE = 18,
  parameter int IRQ_BIT    = 7,
  parameter logic [7:0] STAT_ID = 8'h61
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              frame_end,
  output logic              irq
);
  localparam int WINDOW    = 1 << ADDR_W;
  localparam int NUM_STORE = WINDOW - STORE_BASE;

  logic [7:0] ctrl_q;
  logic       pend_q;
  logic [7:0] store_q [NUM_STORE];
  logic [7:0] rd_byte;

  wire [7:0] wbyte     = bus_wdata[7:0];
  wire       unused_hi = ^bus_wdata[DATA_W-1:8];
  wire       hit_ctrl  = bus_addr == ADDR_W'(CTRL_OFS);
  wire       hit_stat  = bus_addr == ADDR_W'(STAT_OFS);
  wire       set_pend  = frame_end & ctrl_q[IRQ_BIT];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 ctrl_q <= '0;
    else if (bus_wen && hit_ctrl) ctrl_q <= wbyte;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 pend_q <= 1'b0;
    else if (set_pend)          pend_q <= 1'b1;
    else if (bus_wen && hit_stat) pend_q <= 1'b0;

  for (genvar i = 0; i < NUM_STORE; i++) begin : g_store
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) store_q[i] <= '0;
      else if (bus_wen && bus_addr == ADDR_W'(STORE_BASE + i)) store_q[i] <= wbyte;
  end

  always_comb begin
    rd_byte = '0;
    if (hit_ctrl) rd_byte = ctrl_q;
    if (hit_stat) rd_byte = STAT_ID | (8'(pend_q) << IRQ_BIT);
    for (int i = 0; i < NUM_STORE; i++)
      if (bus_addr == ADDR_W'(STORE_BASE + i)) rd_byte = store_q[i];
  end

  assign bus_rdata = {{(DATA_W-8){1'b0}}, rd_byte};
  assign irq       = pend_q;
endmodule

module fbc_regfile_chk #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wen,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              frame_end,
  input logic              armed,
  input logic              irq
);
  // R4
  set_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && armed |=> irq);
  // R5
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wen && bus_addr == 5'h11 && !(frame_end && armed) |=> !irq);
  // R10
  irq_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_end && armed) && !(bus_wen && bus_addr == 5'h11) |=> $stable(irq));
  // R3
  stat_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == 5'h11 |-> bus_rdata[7:0] == ({irq, 7'b0} | 8'h61));
  // R7
  low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr < 5'h10 |-> bus_rdata == '0);
  // R9
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:8] == '0);
endmodule

bind fbc_regfile fbc_regfile_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
  .bus_rdata(bus_rdata), .frame_end(frame_end), .armed(ctrl_q[7]), .irq(irq));

// File: tb/fbc_regfile_bench.sv
`timescale 1ns/1ps
module fbc_regfile_bench;
  logic clk = 0, rst_n = 0, bus_wen = 0, frame_end = 0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq;
  int runs = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fbc_regfile u_fbc_regfile (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
    .bus_wen(bus_wen), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .frame_end(frame_end), .irq(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a; #0.5; d = bus_rdata;
  endtask

  task automatic cyc(input logic [4:0] a, input logic [31:0] d, input logic w, input logic fe);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wen = w; frame_end = fe;
    @(negedge clk); bus_wen = 0; frame_end = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq", 32'(irq), 0);
    rd(5'h10, d); chk("R1 ctrl", d, 0);
    rd(5'h11, d); chk("R1 status", d, 32'h61);
    for (int a = 18; a < 32; a++) begin rd(5'(a), d); chk("R1 store", d, 0); end
  endtask

  task automatic t_ctrl;
    logic [31:0] d;
    cyc(5'h10, 32'hDEAD_BE5A, 1, 0); rd(5'h10, d); chk("R2 ctrl low byte", d, 32'h5A);
    cyc(5'h00, 0, 0, 1); chk("R4 unarmed strobe", 32'(irq), 0);
    rd(5'h11, d); chk("R4 unarmed status", d, 32'h61);
  endtask

  task automatic t_frame;
    logic [31:0] d;
    cyc(5'h10, 32'h80, 1, 0);
    cyc(5'h00, 0, 0, 1); chk("R4 irq set", 32'(irq), 1);
    rd(5'h11, d); chk("R3 status pending", d, 32'hE1);
    repeat (3) @(negedge clk); chk("R10 level held", 32'(irq), 1);
    cyc(5'h11, 32'h00, 1, 0); chk("R5 irq cleared", 32'(irq), 0);
    rd(5'h11, d); chk("R5 status after ack", d, 32'h61);
    cyc(5'h11, 32'hFF, 1, 0); rd(5'h11, d); chk("R5 data not stored", d, 32'h61);
  endtask

  task automatic t_race;
    cyc(5'h11, 32'h80, 1, 1); chk("R8 set wins", 32'(irq), 1);
    cyc(5'h11, 0, 1, 0); chk("R8 then cleared", 32'(irq), 0);
  endtask

  task automatic t_store;
    logic [31:0] d;
    for (int a = 18; a < 32; a++) cyc(5'(a), 32'hAB00_0000 | 32'(a * 7), 1, 0);
    for (int a = 18; a < 32; a++) begin rd(5'(a), d); chk("R6 store", d, 32'((a * 7) & 8'hFF)); end
    cyc(5'h15, 32'h1234_56C3, 1, 0); rd(5'h15, d); chk("R9 upper zero", d, 32'hC3);
  endtask

  task automatic t_unimpl;
    logic [31:0] d;
    cyc(5'h05, 32'hFF, 1, 0); rd(5'h05, d); chk("R7 low read", d, 0);
    rd(5'h15, d); chk("R7 alias untouched", d, 32'hC3);
    cyc(5'h00, 32'h00, 1, 0); rd(5'h10, d); chk("R7 ctrl untouched", d, 32'h80);
    cyc(5'h01, 32'hFF, 1, 0); rd(5'h11, d); chk("R7 no ack", d, 32'h61);
  endtask

  initial begin
    fork
      begin
        #3; @(negedge clk); rst_n = 1;
        t_reset(); t_ctrl(); t_frame(); t_race(); t_store(); t_unimpl();
        done = 1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin runs++; fails++; $display("FAIL watchdog actual=hung expected=done"); end
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule